// File: doc/BRIEF.md
# Sign-Extending Word Load Unit

This block handles one load instruction at a time from a small family of 64-bit loads. Each load fetches a 32-bit word and widens it with sign extension. The family has three forms: a displacement form, an indexed form and an indexed form that also updates the base register.

An instruction word enters on a valid/ready channel. While the instruction is offered, the block decodes it and reads its operands through two combinational register-file read ports. It latches the effective address, issues one 4-byte read on a valid/ready request channel, and waits for the response strobe. It then finishes in one writeback cycle. In that cycle a one-cycle done pulse appears together with the destination write and, for the update form, the base write.

Some words are not valid loads. A word that matches no form raises an illegal flag. An update-form word whose register fields break its rules raises an invalid-form flag. In both cases the flag appears with the done pulse, and the block makes no memory request and no register write.

Back-pressure rules:
- An instruction is taken on a cycle where both `insn_valid` and `insn_ready` are high. `insn_ready` is high only while the unit is idle.
- While the request is outstanding, `mem_req_valid` stays high and `mem_req_addr` stays unchanged until `mem_req_ready` is seen.
- The response channel has no ready signal. The unit takes `mem_rsp_data` on the first `mem_rsp_valid` after the request handshake and ignores the strobe at any other time.

Top module: `swload_unit`

## Requirements
- R1: A word with bits [31:26] = 58 and bits [1:0] = 2 is a displacement load. Destination is bits [25:21], base is bits [20:16], and a 14-bit signed displacement sits in bits [15:2]. The address is base + sign-extended (displacement × 4). A base field of 0 stands for the value 0, not register 0.
- R2: With bits [31:26] = 58, the values 0, 1 and 3 in bits [1:0] are not accepted. They raise `illegal` and cause no memory request.
- R3: A word with bits [31:26] = 31 and bits [10:1] = 341 is an indexed load. The index register is bits [15:11]. The address is base + index, wrapping modulo 2^64, with a base field of 0 read as 0. Bit 0 is ignored.
- R4: A word with bits [31:26] = 31 and bits [10:1] = 373 is an indexed-update load. It always reads the named base register. It writes the address back to that register in the same cycle as the destination write.
- R5: An indexed-update word whose base field is 0, or equals its destination field, raises `invalid_form` with `done`. It makes no memory request and both write enables stay low.
- R6: Any other word raises `illegal` with `done`. It makes no memory request and no writeback.
- R7: The returned word, with its first memory byte in bits [31:24], is written to the destination sign-extended from bit 31 to 64 bits.
- R8: Exactly one read request is issued per valid load. Its valid and address hold steady through stall cycles until accepted.
- R9: `insn_ready` is high only when idle, so words offered while busy are not taken. `done` lasts exactly one cycle, after which the unit is idle again.
- R10: The address is passed to memory unchanged whatever its low bits; unaligned addresses cause no fault and no flag.
- R11: After reset, including a reset in the middle of a load, the unit is idle with `insn_ready` high and no request, done or write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit idle and able to take a word |
| insn | input | 32 | Instruction word |
| rf_a_idx | output | 5 | Register index for the base read port |
| rf_a_data | input | 64 | Base register value, same cycle |
| rf_b_idx | output | 5 | Register index for the index read port |
| rf_b_data | input | 64 | Index register value, same cycle |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read word, first byte in bits [31:24] |
| wb_dst_en | output | 1 | Destination write enable |
| wb_dst_idx | output | 5 | Destination register |
| wb_dst_data | output | 64 | Sign-extended loaded value |
| wb_base_en | output | 1 | Base write enable (update form) |
| wb_base_idx | output | 5 | Base register |
| wb_base_data | output | 64 | Effective address written back |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unrecognised word, valid with done |
| invalid_form | output | 1 | Update form with bad fields, valid with done |

## Verification
Two functions share a single cycle here. In the update form, the destination write of the sign-extended data and the base write of the effective address must land together in the one writeback cycle. The bench triggers this with update-form loads whose addresses wrap around zero or are unaligned, and whose data words have bit 31 both set and clear. It judges the writeback cycle by requiring both enables high at once, each with its own index and value, and by requiring both low in the following cycle. Invalid update forms, where the base equals the destination, are run as well; they must show the flag with done and neither enable.

// File: rtl/swload_pkg.sv
package swload_pkg;
  localparam int RIDX_W = 5;
  localparam int INSN_W = 32;

  localparam logic [5:0] OPC_DISP = 6'd58;
  localparam logic [5:0] OPC_EXT  = 6'd31;
  localparam logic [1:0] SUB_WORD = 2'd2;
  localparam logic [9:0] XO_IDX   = 10'd341;
  localparam logic [9:0] XO_UPD   = 10'd373;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WB
  } ld_state_e;
endpackage

// File: rtl/swload_sext.sv
module swload_sext #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 64
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W > IN_W) begin : g_widen
      assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_same
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/swload_decode.sv
module swload_decode
  import swload_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              is_disp,
  output logic              is_upd,
  output logic              illegal,
  output logic              invalid,
  output logic              zero_base,
  output logic [RIDX_W-1:0] rt,
  output logic [RIDX_W-1:0] ra,
  output logic [RIDX_W-1:0] rb,
  output logic [13:0]       ds
);
  logic [5:0] opc;
  logic [1:0] sub;
  logic [9:0] xo;
  logic       is_idx;

  assign opc = insn[31:26];
  assign sub = insn[1:0];
  assign xo  = insn[10:1];
  assign rt  = insn[25:21];
  assign ra  = insn[20:16];
  assign rb  = insn[15:11];
  assign ds  = insn[15:2];

  always_comb begin
    is_disp = (opc == OPC_DISP) && (sub == SUB_WORD);
    is_idx  = (opc == OPC_EXT) && (xo == XO_IDX);
    is_upd  = (opc == OPC_EXT) && (xo == XO_UPD);
    illegal = !(is_disp || is_idx || is_upd);
    invalid = is_upd && ((ra == '0) || (ra == rt));
    zero_base = !is_upd && (ra == '0);
  end
endmodule

// File: rtl/swload_agen.sv
module swload_agen #(
  parameter int XLEN = 64
) (
  input  logic            is_disp,
  input  logic            zero_base,
  input  logic [13:0]     ds,
  input  logic [XLEN-1:0] a_data,
  input  logic [XLEN-1:0] b_data,
  output logic [XLEN-1:0] ea
);
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  swload_sext #(.IN_W(16), .OUT_W(XLEN)) u_disp_ext (
    .din  ({ds, 2'b00}),
    .dout (disp_ext)
  );

  always_comb begin
    base = zero_base ? '0 : a_data;
    offs = is_disp ? disp_ext : b_data;
    ea   = base + offs;
  end
endmodule

// File: rtl/swload_ctrl.sv
module swload_ctrl
  import swload_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic              d_upd,
  input  logic              d_illegal,
  input  logic              d_invalid,
  input  logic [RIDX_W-1:0] d_rt,
  input  logic [RIDX_W-1:0] d_ra,
  input  logic [XLEN-1:0]   ea_in,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   ea_out,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic [WORD_W-1:0] word_out,
  output logic              wb_dst_en,
  output logic [RIDX_W-1:0] wb_dst_idx,
  output logic              wb_base_en,
  output logic [RIDX_W-1:0] wb_base_idx,
  output logic              done,
  output logic              illegal,
  output logic              invalid_form
);
  ld_state_e         state;
  logic [XLEN-1:0]   ea_q;
  logic [WORD_W-1:0] word_q;
  logic [RIDX_W-1:0] rt_q, ra_q;
  logic              upd_q, ill_q, inv_q;
  logic              in_wb, ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ea_q   <= '0;
      word_q <= '0;
      rt_q   <= '0;
      ra_q   <= '0;
      upd_q  <= 1'b0;
      ill_q  <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (insn_valid) begin
          rt_q  <= d_rt;
          ra_q  <= d_ra;
          upd_q <= d_upd;
          ill_q <= d_illegal;
          inv_q <= d_invalid;
          ea_q  <= ea_in;
          state <= (d_illegal || d_invalid) ? ST_WB : ST_REQ;
        end
        ST_REQ: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          word_q <= mem_rsp_data;
          state  <= ST_WB;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    in_wb         = (state == ST_WB);
    ok            = !ill_q && !inv_q;
    insn_ready    = (state == ST_IDLE);
    mem_req_valid = (state == ST_REQ);
    ea_out        = ea_q;
    word_out      = word_q;
    done          = in_wb;
    wb_dst_en     = in_wb && ok;
    wb_base_en    = in_wb && ok && upd_q;
    wb_dst_idx    = rt_q;
    wb_base_idx   = ra_q;
    illegal       = in_wb && ill_q;
    invalid_form  = in_wb && inv_q;
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(ea_out));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && insn_ready);

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_ready |=> !insn_ready);

  // R6
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_ready && (d_illegal || d_invalid)
      |=> done && !mem_req_valid && !wb_dst_en && !wb_base_en);

  // R4
  base_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_base_en |-> wb_dst_en && (wb_base_idx != wb_dst_idx));
endmodule

// File: rtl/swload_unit.sv
module swload_unit
  import swload_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [INSN_W-1:0] insn,
  output logic [RIDX_W-1:0] rf_a_idx,
  input  logic [XLEN-1:0]   rf_a_data,
  output logic [RIDX_W-1:0] rf_b_idx,
  input  logic [XLEN-1:0]   rf_b_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              wb_dst_en,
  output logic [RIDX_W-1:0] wb_dst_idx,
  output logic [XLEN-1:0]   wb_dst_data,
  output logic              wb_base_en,
  output logic [RIDX_W-1:0] wb_base_idx,
  output logic [XLEN-1:0]   wb_base_data,
  output logic              done,
  output logic              illegal,
  output logic              invalid_form
);
  logic              d_disp, d_upd, d_ill, d_inv, d_zero;
  logic [RIDX_W-1:0] d_rt, d_ra, d_rb;
  logic [13:0]       d_ds;
  logic [XLEN-1:0]   ea;
  logic [XLEN-1:0]   ea_q;
  logic [WORD_W-1:0] word_q;

  swload_decode u_dec (
    .insn      (insn),
    .is_disp   (d_disp),
    .is_upd    (d_upd),
    .illegal   (d_ill),
    .invalid   (d_inv),
    .zero_base (d_zero),
    .rt        (d_rt),
    .ra        (d_ra),
    .rb        (d_rb),
    .ds        (d_ds)
  );

  assign rf_a_idx = d_ra;
  assign rf_b_idx = d_rb;

  swload_agen #(.XLEN(XLEN)) u_agen (
    .is_disp   (d_disp),
    .zero_base (d_zero),
    .ds        (d_ds),
    .a_data    (rf_a_data),
    .b_data    (rf_b_data),
    .ea        (ea)
  );

  swload_ctrl #(.XLEN(XLEN), .WORD_W(WORD_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_valid    (insn_valid),
    .insn_ready    (insn_ready),
    .d_upd         (d_upd),
    .d_illegal     (d_ill),
    .d_invalid     (d_inv),
    .d_rt          (d_rt),
    .d_ra          (d_ra),
    .ea_in         (ea),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .ea_out        (ea_q),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .word_out      (word_q),
    .wb_dst_en     (wb_dst_en),
    .wb_dst_idx    (wb_dst_idx),
    .wb_base_en    (wb_base_en),
    .wb_base_idx   (wb_base_idx),
    .done          (done),
    .illegal       (illegal),
    .invalid_form  (invalid_form)
  );

  swload_sext #(.IN_W(WORD_W), .OUT_W(XLEN)) u_data_ext (
    .din  (word_q),
    .dout (wb_dst_data)
  );

  assign mem_req_addr = ea_q;
  assign wb_base_data = ea_q;

  // R7
  rsp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && !insn_ready && !mem_req_valid && !done
      |=> wb_dst_data[WORD_W-1:0] == $past(mem_rsp_data));

  // R10
  no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !illegal && !invalid_form);
endmodule

// File: tb/tb_swload_unit.sv
`timescale 1ns/1ps
module tb_swload_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn = '0;
  logic [4:0]  rf_a_idx, rf_b_idx;
  logic [63:0] rf_a_data, rf_b_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wb_dst_en, wb_base_en, done, illegal, invalid_form;
  logic [4:0]  wb_dst_idx, wb_base_idx;
  logic [63:0] wb_dst_data, wb_base_data;

  int checks = 0;
  int errors = 0;
  int nreq = 0;
  logic [63:0] regs [32];

  always #10 clk = ~clk;

  swload_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn(insn), .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data),
    .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .wb_dst_en(wb_dst_en), .wb_dst_idx(wb_dst_idx),
    .wb_dst_data(wb_dst_data), .wb_base_en(wb_base_en), .wb_base_idx(wb_base_idx),
    .wb_base_data(wb_base_data), .done(done), .illegal(illegal),
    .invalid_form(invalid_form)
  );

  assign rf_a_data = regs[rf_a_idx];
  assign rf_b_data = regs[rf_b_idx];

  always @(posedge clk) if (rst_n && mem_req_valid && mem_req_ready) nreq++;

  function automatic logic [31:0] dsf(input logic [4:0] rt, input logic [4:0] ra,
                                      input logic [13:0] ds, input logic [1:0] sub);
    return {6'd58, rt, ra, ds, sub};
  endfunction

  function automatic logic [31:0] xf(input logic [4:0] rt, input logic [4:0] ra,
                                     input logic [4:0] rb, input logic [9:0] xo,
                                     input logic rc);
    return {6'd31, rt, ra, rb, xo, rc};
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] mdata;
    logic [1:0]  kind;   // 0 load, 1 illegal, 2 invalid form
    logic        upd;
    logic [63:0] eaddr;
    logic [63:0] edst;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{dsf(5'd3, 5'd2, 14'd5, 2'd2),      32'h7FFF0001, 2'd0, 1'b0, 64'h2014,             64'h000000007FFF0001},
    '{dsf(5'd4, 5'd0, 14'h3FFF, 2'd2),   32'h80000000, 2'd0, 1'b0, 64'hFFFFFFFFFFFFFFFC, 64'hFFFFFFFF80000000},
    '{dsf(5'd1, 5'd7, 14'd2, 2'd2),      32'hFFFFFFFF, 2'd0, 1'b0, 64'h4,                64'hFFFFFFFFFFFFFFFF},
    '{dsf(5'd6, 5'd9, 14'h2000, 2'd2),   32'h12345678, 2'd0, 1'b0, 64'h1000,             64'h0000000012345678},
    '{dsf(5'd3, 5'd2, 14'd5, 2'd0),      32'h0,        2'd1, 1'b0, 64'h0,                64'h0},
    '{dsf(5'd3, 5'd2, 14'd5, 2'd1),      32'h0,        2'd1, 1'b0, 64'h0,                64'h0},
    '{dsf(5'd3, 5'd2, 14'd5, 2'd3),      32'h0,        2'd1, 1'b0, 64'h0,                64'h0},
    '{xf(5'd5, 5'd3, 5'd4, 10'd341, 1'b0), 32'h00000080, 2'd0, 1'b0, 64'h7000,          64'h80},
    '{xf(5'd9, 5'd0, 5'd6, 10'd341, 1'b1), 32'hC0000001, 2'd0, 1'b0, 64'h6000,          64'hFFFFFFFFC0000001},
    '{xf(5'd2, 5'd7, 5'd2, 10'd341, 1'b0), 32'h0000FFFF, 2'd0, 1'b0, 64'h1FFC,          64'hFFFF},
    '{xf(5'd12, 5'd0, 5'd11, 10'd341, 1'b0), 32'h80000001, 2'd0, 1'b0, 64'h3,           64'hFFFFFFFF80000001},
    '{xf(5'd8, 5'd10, 5'd11, 10'd373, 1'b0), 32'h89ABCDEF, 2'd0, 1'b1, 64'hA003,        64'hFFFFFFFF89ABCDEF},
    '{xf(5'd2, 5'd7, 5'd12, 10'd373, 1'b0), 32'h00000001, 2'd0, 1'b1, 64'hBFFC,         64'h1},
    '{xf(5'd3, 5'd0, 5'd4, 10'd373, 1'b0), 32'h0,        2'd2, 1'b0, 64'h0,             64'h0},
    '{xf(5'd6, 5'd6, 5'd4, 10'd373, 1'b0), 32'h0,        2'd2, 1'b0, 64'h0,             64'h0},
    '{xf(5'd3, 5'd2, 5'd4, 10'd340, 1'b0), 32'h0,        2'd1, 1'b0, 64'h0,             64'h0},
    '{32'h80000000,                      32'h0,        2'd1, 1'b0, 64'h0,             64'h0}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.insn[31:26] == 6'd58) return (v.kind == 2'd0) ? "R1" : "R2";
    if (v.kind == 2'd2) return "R5";
    if (v.kind == 2'd1) return "R6";
    if (v.upd) return "R4";
    return "R3";
  endfunction

  task automatic run_vec(input vec_t v);
    string t;
    t = tag_of(v);
    @(negedge clk);
    chk("R9", "ready before offer", {63'd0, insn_ready}, 64'd1);
    insn = v.insn;
    insn_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    if (v.kind == 2'd0) begin
      chk(t, "req valid", {63'd0, mem_req_valid}, 64'd1);
      chk((v.eaddr[1:0] != 2'b00) ? "R10" : t, "req addr", mem_req_addr, v.eaddr);
      // offer a stray word while busy: must not be taken (R9)
      insn = 32'h80000000;
      insn_valid = 1'b1;
      chk("R9", "ready while busy", {63'd0, insn_ready}, 64'd0);
      @(posedge clk);
      @(negedge clk);
      insn_valid = 1'b0;
      chk("R8", "req held", {63'd0, mem_req_valid}, 64'd1);
      chk("R8", "addr held", mem_req_addr, v.eaddr);
      mem_req_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R8", "req dropped", {63'd0, mem_req_valid}, 64'd0);
      @(negedge clk);
      chk(t, "no early done", {63'd0, done}, 64'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data = v.mdata;
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
    chk(t, "done", {63'd0, done}, 64'd1);
    chk(t, "illegal", {63'd0, illegal}, {63'd0, v.kind == 2'd1});
    chk(t, "invalid_form", {63'd0, invalid_form}, {63'd0, v.kind == 2'd2});
    chk(t, "dst en", {63'd0, wb_dst_en}, {63'd0, v.kind == 2'd0});
    chk(t, "base en", {63'd0, wb_base_en}, {63'd0, (v.kind == 2'd0) && v.upd});
    chk(t, "no req in wb", {63'd0, mem_req_valid}, 64'd0);
    if (v.kind == 2'd0) begin
      chk(t, "dst idx", {59'd0, wb_dst_idx}, {59'd0, v.insn[25:21]});
      chk("R7", "dst data", wb_dst_data, v.edst);
      if (v.upd) begin
        chk("R4", "base idx", {59'd0, wb_base_idx}, {59'd0, v.insn[20:16]});
        chk("R4", "base data", wb_base_data, v.eaddr);
      end
    end
    @(negedge clk);
    chk("R9", "done pulse ends", {62'd0, done, wb_dst_en}, 64'd0);
    chk("R9", "base en ends", {63'd0, wb_base_en}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'h1000 * i;
    regs[0]  = 64'hDEAD0000;
    regs[7]  = 64'hFFFFFFFFFFFFFFFC;
    regs[11] = 64'h3;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset ready", {63'd0, insn_ready}, 64'd1);
    chk("R11", "reset outputs", {60'd0, mem_req_valid, done, wb_dst_en, wb_base_en}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R6: only the valid loads produced memory requests
    chk("R6", "request count", 64'(nreq), 64'd10);

    // R11: reset in the middle of a load
    @(negedge clk);
    insn = TBL[0].insn;
    insn_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    mem_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "mid reset ready", {63'd0, insn_ready}, 64'd1);
    chk("R11", "mid reset outputs", {61'd0, mem_req_valid, done, wb_dst_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(TBL[11]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule